// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a small synchronous static RAM, 256 words of 36 bits by default, that never needs an idle cycle when the shared data bus changes direction. Each command (address and controls) is captured on a rising clock edge. Its data moves during the cycle that follows, and the array is updated on the next edge. Because every data phase trails its command by exactly one cycle, reads and writes can be issued on every cycle in any mix.

Read data is flow-through. The word leaves the array combinationally during the data cycle, with no output register. The data bus is modelled as three signals: a write-data input, a read-data output and a drive flag that an external pad would use as its tri-state enable. An asynchronous active-low enable can turn that drive off at any time. A four-word burst sequencer lets one loaded address be followed by advance cycles, in either linear or interleaved order. Each 9-bit lane has its own active-low write select.

Top module: `zbt_sram`

## Requirements
- R1: A command is taken on the rising edge where `run_n`=0. Its data phase is the following cycle. Read data for it appears on `rdata` during that cycle. Write data for it is taken from `wdata` on the edge that ends that cycle, if `run_n`=0 on that edge.
- R2: Reads and writes can be issued on consecutive cycles in any order with no idle cycle. A read issued directly after a write to the same address returns the newly merged word.
- R3: Read data is flow-through. In the data cycle of a read, `rdata` equals the stored word at the read address before the next clock edge arrives.
- R4: On an edge where `run_n`=1, every input is ignored and every register holds. A pending read keeps its output, and a pending write does not commit.
- R5: A new operation starts only when `new_cmd_n`=0 together with `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load with any select inactive is a deselect, and no data phase follows it.
- R6: A deselect does not cancel a transfer that is already pending. That transfer still completes in its data cycle.
- R7: `rdata_drive` is 0 in the cycle after a deselect is issued and in the cycle after a write is issued.
- R8: While `drive_en_n`=1, `rdata_drive` is 0 at once, in any pipeline state. When no read data phase is active, `rdata` is 0.
- R9: Lane i is bits [9i+8:9i]. A write changes lane i only if `lane_we_n[i]`=0 in that write's command cycle.
- R10: `new_cmd_n`=1 advances an active burst and keeps the loading command's direction. With base low bits b and k the advance count mod 4, the address low two bits are (b+k) mod 4 when `seq_linear`=1 and b XOR k when `seq_linear`=0. The upper address bits are unchanged.
- R11: An advance cycle with no active burst, either after reset or after a deselect, starts nothing.
- R12: After reset there is no pending transfer, `rdata_drive` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| run_n | input | 1 | Active-low clock enable; 1 suspends the block |
| new_cmd_n | input | 1 | 0 loads a new command, 1 advances the burst |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| read_nwrite | input | 1 | 1 for a read, 0 for a write (sampled on load) |
| lane_we_n | input | LANES | Active-low per-lane write selects |
| cmd_addr | input | ADDR_W | Command word address |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| drive_en_n | input | 1 | Asynchronous active-low output drive enable |
| wdata | input | LANES*LANE_W | Write data for the pending write |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_drive | output | 1 | Data bus drive enable |

## Verification
The assertions take for granted that all inputs are known after reset and that `seq_linear` does not change in the middle of a burst. The random stimulus changes `seq_linear` only on a cycle where it also forces a deselect, so no burst crosses the change. The lane-commit property checks the array element that the previous write addressed. For that reason the bench fills every word before any random read, so no unknown word is ever compared. Random suspend cycles, chip-select patterns and drive-enable pulses are kept to about one cycle in ten. This leaves long back-to-back command runs alongside the corner cases.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic {
        SEQ_INTERLEAVED = 1'b0,
        SEQ_LINEAR      = 1'b1
    } seq_order_e;

    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] base_lo,
        input logic [BURST_W-1:0] step,
        input seq_order_e         order
    );
        if (order == SEQ_LINEAR) begin
            return base_lo + step;
        end
        return base_lo ^ step;
    endfunction

endpackage

// File: rtl/zbt_sram_burst.sv
module zbt_sram_burst
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [BURST_W-1:0] step_cur,
    input  logic               seq_linear,
    output logic [BURST_W-1:0] step_nxt,
    output logic [ADDR_W-1:0]  addr_nxt
);

    seq_order_e order;

    always_comb begin
        order    = seq_linear ? SEQ_LINEAR : SEQ_INTERLEAVED;
        step_nxt = step_cur + 1'b1;
        addr_nxt = {base_addr[ADDR_W-1:BURST_W],
                    burst_offset(base_addr[BURST_W-1:0], step_nxt, order)};
    end

endmodule

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_n,
    input  logic              new_cmd_n,
    input  logic              selected,
    input  logic              read_nwrite,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              seq_linear,
    output logic              ph_valid,
    output logic              ph_write,
    output logic [ADDR_W-1:0] ph_addr,
    output logic [LANES-1:0]  ph_lanes
);

    typedef struct packed {
        logic               burst_on;
        logic               burst_wr;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] step;
        logic               ph_valid;
        logic               ph_write;
        logic [ADDR_W-1:0]  ph_addr;
        logic [LANES-1:0]   ph_lanes;
    } ctrl_t;

    ctrl_t              st_d, st_q;
    logic [BURST_W-1:0] adv_step;
    logic [ADDR_W-1:0]  adv_addr;

    zbt_sram_burst #(.ADDR_W(ADDR_W)) i_burst (
        .base_addr  (st_q.base),
        .step_cur   (st_q.step),
        .seq_linear (seq_linear),
        .step_nxt   (adv_step),
        .addr_nxt   (adv_addr)
    );

    always_comb begin
        st_d = st_q;
        if (!run_n) begin
            st_d.ph_lanes = ~lane_we_n;
            if (!new_cmd_n) begin
                if (selected) begin
                    st_d.burst_on = 1'b1;
                    st_d.burst_wr = !read_nwrite;
                    st_d.base     = cmd_addr;
                    st_d.step     = '0;
                    st_d.ph_valid = 1'b1;
                    st_d.ph_write = !read_nwrite;
                    st_d.ph_addr  = cmd_addr;
                end else begin
                    st_d.burst_on = 1'b0;
                    st_d.ph_valid = 1'b0;
                    st_d.ph_write = 1'b0;
                end
            end else if (st_q.burst_on) begin
                st_d.step     = adv_step;
                st_d.ph_valid = 1'b1;
                st_d.ph_write = st_q.burst_wr;
                st_d.ph_addr  = adv_addr;
            end else begin
                st_d.ph_valid = 1'b0;
                st_d.ph_write = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_valid = st_q.ph_valid;
    assign ph_write = st_q.ph_write;
    assign ph_addr  = st_q.ph_addr;
    assign ph_lanes = st_q.ph_lanes;

    assert_suspend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_n |=> ($stable(ph_valid) && $stable(ph_write) && $stable(ph_addr) && $stable(ph_lanes)));

    assert_load_next_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && !new_cmd_n && selected) |=>
            (ph_valid && ph_addr == $past(cmd_addr) && ph_write == !$past(read_nwrite)));

    assert_deselect_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && !new_cmd_n && !selected) |=> !ph_valid);

    assert_advance_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && new_cmd_n && st_q.burst_on) |=>
            (ph_valid && ph_addr[ADDR_W-1:BURST_W] == $past(st_q.base[ADDR_W-1:BURST_W])));

    assert_idle_advance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && new_cmd_n && !st_q.burst_on) |=> !ph_valid);

endmodule

// File: rtl/zbt_sram_array.sv
module zbt_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                mem_q[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem_q[rd_addr];

        assert_lane_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_lanes[g]) |=>
                (mem_q[$past(wr_addr)] == $past(wr_data[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_n,
    input  logic                    new_cmd_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    read_nwrite,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic                    seq_linear,
    input  logic                    drive_en_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive
);

    localparam int DATA_W = LANES * LANE_W;

    logic              selected;
    logic              ph_valid;
    logic              ph_write;
    logic [ADDR_W-1:0] ph_addr;
    logic [LANES-1:0]  ph_lanes;
    logic              commit;
    logic              rd_phase;
    logic [DATA_W-1:0] array_q;

    assign selected = !sel_a_n && sel_b && !sel_c_n;

    zbt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_n       (run_n),
        .new_cmd_n   (new_cmd_n),
        .selected    (selected),
        .read_nwrite (read_nwrite),
        .lane_we_n   (lane_we_n),
        .cmd_addr    (cmd_addr),
        .seq_linear  (seq_linear),
        .ph_valid    (ph_valid),
        .ph_write    (ph_write),
        .ph_addr     (ph_addr),
        .ph_lanes    (ph_lanes)
    );

    assign commit   = !run_n && ph_valid && ph_write;
    assign rd_phase = ph_valid && !ph_write;

    zbt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .wr_addr  (ph_addr),
        .wr_lanes (ph_lanes),
        .wr_data  (wdata),
        .rd_addr  (ph_addr),
        .rd_data  (array_q)
    );

    assign rdata       = rd_phase ? array_q : '0;
    assign rdata_drive = rd_phase && !drive_en_n;

    assert_drive_forced_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_n |-> !rdata_drive);

    assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n && !new_cmd_n && !(selected && read_nwrite)) |=> !rdata_drive);

    assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_phase |-> (rdata == '0));

endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;

    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_n = 1'b0;
    logic          new_cmd_n = 1'b1;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          read_nwrite = 1'b1;
    logic [NL-1:0] lane_we_n = '1;
    logic [AW-1:0] cmd_addr = '0;
    logic          seq_linear = 1'b1;
    logic          drive_en_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R12";

    // reference model state
    logic [DW-1:0] mdl [256];
    logic          m_on = 1'b0;
    logic          m_wr = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = '0;
    logic          p_valid = 1'b0;
    logic          p_write = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [NL-1:0] p_lanes = '0;

    zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_zbt_sram (
        .clk, .rst_n, .run_n, .new_cmd_n, .sel_a_n, .sel_b, .sel_c_n,
        .read_nwrite, .lane_we_n, .cmd_addr, .seq_linear, .drive_en_n,
        .wdata, .rdata, .rdata_drive
    );

    always #10 clk = ~clk;

    function automatic logic [1:0] exp_low(input logic [1:0] b, input logic [1:0] k,
                                           input logic lin);
        return lin ? (b + k) : (b ^ k);
    endfunction

    task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, got, exp);
        end
    endtask

    // called right after a falling edge with inputs already set
    task automatic tick();
        logic sel;
        #5;
        chk({35'd0, rdata_drive}, {35'd0, p_valid && !p_write && !drive_en_n}, "drive");
        if (p_valid && !p_write) chk(rdata, mdl[p_addr], "read data");
        else                     chk(rdata, '0, "idle data");
        sel = !sel_a_n && sel_b && !sel_c_n;
        if (!run_n) begin
            if (p_valid && p_write) begin
                for (int i = 0; i < NL; i++)
                    if (p_lanes[i]) mdl[p_addr][i*LW +: LW] = wdata[i*LW +: LW];
            end
            p_lanes = ~lane_we_n;
            if (!new_cmd_n) begin
                if (sel) begin
                    m_on = 1'b1; m_wr = !read_nwrite; m_base = cmd_addr; m_step = 2'd0;
                    p_valid = 1'b1; p_write = !read_nwrite; p_addr = cmd_addr;
                end else begin
                    m_on = 1'b0; p_valid = 1'b0; p_write = 1'b0;
                end
            end else if (m_on) begin
                m_step = m_step + 2'd1;
                p_valid = 1'b1; p_write = m_wr;
                p_addr = {m_base[AW-1:2], exp_low(m_base[1:0], m_step, seq_linear)};
            end else begin
                p_valid = 1'b0; p_write = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic op(input logic ld_n, input logic rw, input logic [AW-1:0] a,
                      input logic [NL-1:0] we_n, input logic [DW-1:0] d);
        run_n = 1'b0; new_cmd_n = ld_n;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        read_nwrite = rw; cmd_addr = a; lane_we_n = we_n; wdata = d; drive_en_n = 1'b0;
        tick();
    endtask

    task automatic desel(input logic [DW-1:0] d);
        run_n = 1'b0; new_cmd_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
        wdata = d; drive_en_n = 1'b0;
        tick();
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_tag = "R12";
        chk({35'd0, rdata_drive}, '0, "reset drive");
        chk(rdata, '0, "reset data");
        rst_n = 1'b1;
        desel('0);
        // R11: advance straight after reset starts nothing
        cur_tag = "R11";
        op(1'b1, 1'b1, 8'h00, 4'h0, '0);
        op(1'b1, 1'b1, 8'h00, 4'h0, '0);

        // fill every word back to back (R1, R2)
        cur_tag = "R1";
        for (int a = 0; a < 256; a++) op(1'b0, 1'b0, a[AW-1:0], 4'h0, rnd_word());
        op(1'b0, 1'b1, 8'd0, 4'hF, rnd_word());
        op(1'b0, 1'b1, 8'd255, 4'hF, rnd_word());

        // R2: mixed write/read same address, with masked merge
        cur_tag = "R2";
        op(1'b0, 1'b0, 8'h21, 4'h0, '0);
        op(1'b0, 1'b1, 8'h21, 4'hF, 36'h1_2345_6789);
        op(1'b0, 1'b0, 8'h21, 4'b0110, '0);
        op(1'b0, 1'b1, 8'h21, 4'hF, 36'hF_EDCB_A987);
        op(1'b0, 1'b0, 8'h22, 4'h0, '0);
        op(1'b0, 1'b1, 8'h22, 4'hF, 36'h0_AAAA_5555);
        desel('0);

        // R9: single lanes
        cur_tag = "R9";
        op(1'b0, 1'b0, 8'h40, 4'b1010, '0);
        op(1'b0, 1'b0, 8'h41, 4'b1110, 36'hA_BCDE_F012);
        op(1'b0, 1'b1, 8'h40, 4'hF, 36'h3_3333_3333);
        op(1'b0, 1'b1, 8'h41, 4'hF, '0);
        desel('0);

        // R4: suspend during read and during write data phase
        cur_tag = "R4";
        op(1'b0, 1'b1, 8'h10, 4'hF, '0);
        for (int i = 0; i < 3; i++) begin
            run_n = 1'b1; new_cmd_n = 1'b0; read_nwrite = 1'b0; cmd_addr = 8'h77;
            lane_we_n = 4'h0; wdata = rnd_word();
            tick();
        end
        op(1'b0, 1'b0, 8'h11, 4'h0, '0);
        for (int i = 0; i < 3; i++) begin
            run_n = 1'b1; new_cmd_n = 1'b0; read_nwrite = 1'b1; cmd_addr = 8'h12;
            wdata = rnd_word();
            tick();
        end
        op(1'b0, 1'b1, 8'h11, 4'hF, 36'h5_0505_0505);
        desel('0);

        // R5: each select inactive on a load
        cur_tag = "R5";
        for (int v = 0; v < 8; v++) begin
            run_n = 1'b0; new_cmd_n = 1'b0; read_nwrite = 1'b1; cmd_addr = 8'h30;
            {sel_a_n, sel_b, sel_c_n} = v[2:0];
            tick();
        end

        // R6: pending read and write survive a deselect
        cur_tag = "R6";
        op(1'b0, 1'b1, 8'h50, 4'hF, '0);
        desel('0);
        op(1'b0, 1'b0, 8'h51, 4'h0, '0);
        desel(36'h6_6666_0000);
        op(1'b0, 1'b1, 8'h51, 4'hF, '0);
        desel('0);

        // R7: read followed by write releases the bus
        cur_tag = "R7";
        op(1'b0, 1'b1, 8'h60, 4'hF, '0);
        op(1'b0, 1'b0, 8'h61, 4'h0, '0);
        op(1'b0, 1'b1, 8'h60, 4'hF, 36'h7_7777_7777);
        desel('0);

        // R8: drive enable forces drive off in a read phase
        cur_tag = "R8";
        op(1'b0, 1'b1, 8'h03, 4'hF, '0);
        run_n = 1'b0; new_cmd_n = 1'b0; sel_a_n = 1'b1; drive_en_n = 1'b1;
        tick();
        drive_en_n = 1'b0;

        // R10: linear and interleaved bursts from base low bits 1
        cur_tag = "R10";
        for (int m = 0; m < 2; m++) begin
            seq_linear = m[0];
            desel('0);
            op(1'b0, 1'b0, 8'h85, 4'h0, '0);
            for (int k = 0; k < 3; k++) op(1'b1, 1'b1, 8'h00, 4'h0, rnd_word());
            op(1'b0, 1'b1, 8'h85, 4'hF, rnd_word());
            for (int k = 0; k < 4; k++) op(1'b1, 1'b0, 8'h00, 4'hF, '0);
        end
        desel('0);
        cur_tag = "R11";
        op(1'b1, 1'b1, 8'h00, 4'hF, '0);

        // random phase (R3 flow-through data checked every read cycle)
        cur_tag = "R3";
        for (int c = 0; c < 3000; c++) begin
            if (c % 256 == 0) begin
                seq_linear = $urandom % 2;
                desel(rnd_word());
            end
            run_n       = ($urandom % 10 == 0);
            new_cmd_n   = ($urandom % 4 == 0);
            if ($urandom % 10 == 0) {sel_a_n, sel_b, sel_c_n} = 3'($urandom);
            else                    {sel_a_n, sel_b, sel_c_n} = 3'b010;
            read_nwrite = $urandom % 2;
            cmd_addr    = 8'($urandom);
            lane_we_n   = ($urandom % 2 == 0) ? 4'h0 : 4'($urandom);
            drive_en_n  = ($urandom % 10 == 0);
            wdata       = rnd_word();
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule